// File: doc/BRIEF.md
# Raster-Synchronised Display Microsequencer

This block is a small program engine that runs in lockstep with a video raster and produces the draw stream for a debug front-panel overlay. Each clock it looks at one instruction held in an internal constant ROM. The instruction can stall until the beam reaches a given scanline or pixel column, draw one value taken from a debug bus when a condition holds, emit a zero-terminated run of characters, jump, or halt. A downstream glyph renderer turns each draw request into pixels.

The beam position, a display-enable qualifier, a set of condition flags and the debug value bus come in. The block sends out the debug-bus index of the current instruction, a cell-valid flag with its kind and data, and a pixel-active strobe. Each drawn item occupies one 8-pixel cell. The program restarts from address 0 at every frame, so a single program describes the whole overlay.

Top module: `raster_copper`

## Requirements
- R1: While reset is asserted and after it is released, the program counter is 0, draw_valid and pix_active are low, and dbg_idx shows bits 7:0 of ROM word 0.
- R2: An instruction word has its opcode in bits 15:13 and its operand in bits 12:0. Opcode 0 stalls until beam_y equals the operand and then moves to the next address.
- R3: Opcode 1 stalls until beam_x equals the operand and then moves to the next address.
- R4: Opcode 2 is a conditional draw, with the condition select in operand bits 11:8 and the debug index in bits 7:0. dbg_idx always carries bits 7:0 of the current word. When the condition holds, the dbg_val of that cycle is captured and shown from the next cycle as a value cell (draw_kind 0).
- R5: Condition select 0 is always true and 1 is never true. A select k of 2 or more tests cond_flags bit k-2. When the condition is false, no cell is produced and the next address executes on the following cycle.
- R6: Opcode 3 reads the following ROM words one per step as character codes and shows each as a text cell (draw_kind 1). A zero word ends the run, and execution continues at the address after the zero.
- R7: Opcode 4 loads the program counter with the low address bits of the operand.
- R8: Opcodes 5, 6 and 7 halt the program until the next frame restart.
- R9: When beam_y is 0 and it was nonzero on the previous cycle, the program counter returns to 0 and any open cell is dropped.
- R10: A cell lasts for 8 cycles in which disp_en is high. It is held while disp_en is low, and pix_active equals draw_valid AND disp_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beam_x | input | XW | Current pixel column |
| beam_y | input | YW | Current scanline |
| disp_en | input | 1 | Active video area |
| cond_flags | input | 14 | Condition flags tested by draw selects 2..15 |
| dbg_val | input | DW | Debug value chosen by dbg_idx |
| dbg_idx | output | 8 | Debug-bus index of the current instruction |
| draw_valid | output | 1 | A cell is being drawn |
| draw_kind | output | 1 | 0 for a value cell, 1 for a text cell |
| draw_data | output | DW | Captured value or character code |
| pix_active | output | 1 | Overlay pixel is active, so the background is hidden |

## Verification
The raster is swept through several frames. Each frame uses a different flag pattern: all set, all clear, only the lowest tested bit, and only the highest tested bit. Counting value cells per frame therefore tells apart the always, never and flag-bit selects and shows the skipped word behind the jump. A debug bus whose value depends on both the index and a per-frame salt shows whether each value was captured in the cycle of its own instruction and frame. Each line has a blanked tail, so a cell can straddle it, which checks that the cell counter is held while display is disabled. Sampling at the first scanline of each frame and near the last one covers the restart and the halt.

// File: rtl/raster_copper.sv
module raster_copper #(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] beam_x,
  input  logic [YW-1:0] beam_y,
  input  logic          disp_en,
  input  logic [13:0]   cond_flags,
  input  logic [DW-1:0] dbg_val,
  output logic [7:0]    dbg_idx,
  output logic          draw_valid,
  output logic          draw_kind,
  output logic [DW-1:0] draw_data,
  output logic          pix_active
);
  localparam logic [2:0] OP_WY = 3'd0, OP_WX = 3'd1, OP_DV = 3'd2, OP_TX = 3'd3, OP_JP = 3'd4;
  localparam int CELL_W = 8;

  typedef enum logic [1:0] {S_RUN, S_TXT, S_CELL} st_t;

  function automatic logic [15:0] prog(input logic [AW-1:0] a);
    case (int'(a))
      0:  prog = 16'h0002;
      1:  prog = 16'h2003;
      2:  prog = 16'h4005;
      3:  prog = 16'h4106;
      4:  prog = 16'h4207;
      5:  prog = 16'h6000;
      6:  prog = 16'h0048;
      7:  prog = 16'h0049;
      8:  prog = 16'h0000;
      9:  prog = 16'h0005;
      10: prog = 16'h4F09;
      11: prog = 16'h800D;
      12: prog = 16'h4001;
      13: prog = 16'hE000;
      default: prog = 16'h0000;
    endcase
  endfunction

  st_t            st;
  logic [AW-1:0]  pc;
  logic [2:0]     cnt;
  logic [YW-1:0]  prev_y;
  logic [15:0]    word;
  logic [2:0]     opc;
  logic [12:0]    opnd;
  logic [3:0]     sel;
  logic           cond_ok;
  logic           restart;

  assign word    = prog(pc);
  assign opc     = word[15:13];
  assign opnd    = word[12:0];
  assign sel     = word[11:8];
  assign dbg_idx = word[7:0];
  assign restart = (beam_y == '0) && (prev_y != '0);

  always_comb begin
    case (sel)
      4'd0:    cond_ok = 1'b1;
      4'd1:    cond_ok = 1'b0;
      default: cond_ok = cond_flags[sel - 4'd2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_RUN;
      pc        <= '0;
      cnt       <= '0;
      prev_y    <= '0;
      draw_kind <= 1'b0;
      draw_data <= '0;
    end else begin
      prev_y <= beam_y;
      if (restart) begin
        st  <= S_RUN;
        pc  <= '0;
        cnt <= '0;
      end else begin
        case (st)
          S_RUN: begin
            case (opc)
              OP_WY: if (13'(beam_y) == opnd) pc <= pc + 1'b1;
              OP_WX: if (13'(beam_x) == opnd) pc <= pc + 1'b1;
              OP_DV: begin
                pc <= pc + 1'b1;
                if (cond_ok) begin
                  draw_data <= dbg_val;
                  draw_kind <= 1'b0;
                  cnt       <= '0;
                  st        <= S_CELL;
                end
              end
              OP_TX: begin
                pc <= pc + 1'b1;
                st <= S_TXT;
              end
              OP_JP: pc <= opnd[AW-1:0];
              default: ;
            endcase
          end
          S_TXT: begin
            pc <= pc + 1'b1;
            if (word == '0) st <= S_RUN;
            else begin
              draw_data <= DW'(word);
              draw_kind <= 1'b1;
              cnt       <= '0;
              st        <= S_CELL;
            end
          end
          default: begin
            if (disp_en) begin
              cnt <= cnt + 1'b1;
              if (int'(cnt) == CELL_W - 1) st <= draw_kind ? S_TXT : S_RUN;
            end
          end
        endcase
      end
    end
  end

  assign draw_valid = (st == S_CELL);
  assign pix_active = draw_valid & disp_en;
endmodule

// File: rtl/raster_copper_chk.sv
module raster_copper_chk #(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [YW-1:0] beam_y,
  input logic          disp_en,
  input logic [DW-1:0] dbg_val,
  input logic          draw_valid,
  input logic          draw_kind,
  input logic [DW-1:0] draw_data,
  input logic          pix_active
);
  logic [YW-1:0] seen_y;
  logic          wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_y <= '0;
    else        seen_y <= beam_y;
  end
  assign wrap = (beam_y == '0) && (seen_y != '0);

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !draw_valid);

  assert_value_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(draw_valid) && !draw_kind) |-> draw_data == $past(dbg_val));

  assert_text_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_valid && draw_kind) |-> draw_data != '0);

  assert_frame_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !draw_valid);

  assert_blank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_valid && !disp_en && !wrap) |=> (draw_valid && $stable(draw_data)));

  assert_pix_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_active |-> (draw_valid && disp_en));
endmodule

bind raster_copper raster_copper_chk #(.XW(XW), .YW(YW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .beam_y(beam_y), .disp_en(disp_en),
  .dbg_val(dbg_val), .draw_valid(draw_valid), .draw_kind(draw_kind),
  .draw_data(draw_data), .pix_active(pix_active)
);

// File: tb/test_raster_copper.sv
module test_raster_copper;
  localparam int W = 24, H = 8, ACT = 16, FRAMES = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  beam_x = 0;
  logic [9:0]  beam_y = 0;
  logic        disp_en = 0;
  logic [13:0] cond_flags = 0;
  logic [7:0]  salt = 0;
  logic [15:0] dbg_val;
  logic [7:0]  dbg_idx;
  logic        draw_valid, draw_kind, pix_active;
  logic [15:0] draw_data;

  int vectors = 0, fails = 0;
  bit done = 0;

  assign dbg_val = {dbg_idx, dbg_idx ^ salt};

  always #10 clk = ~clk;

  raster_copper i_raster_copper (
    .clk(clk), .rst_n(rst_n), .beam_x(beam_x), .beam_y(beam_y), .disp_en(disp_en),
    .cond_flags(cond_flags), .dbg_val(dbg_val), .dbg_idx(dbg_idx),
    .draw_valid(draw_valid), .draw_kind(draw_kind), .draw_data(draw_data),
    .pix_active(pix_active)
  );

  // program under test, as listed for the bench
  logic [15:0] bprog [0:31];
  initial begin
    for (int i = 0; i < 32; i++) bprog[i] = 16'h0000;
    bprog[0]  = 16'h0002; bprog[1]  = 16'h2003; bprog[2]  = 16'h4005;
    bprog[3]  = 16'h4106; bprog[4]  = 16'h4207; bprog[5]  = 16'h6000;
    bprog[6]  = 16'h0048; bprog[7]  = 16'h0049; bprog[8]  = 16'h0000;
    bprog[9]  = 16'h0005; bprog[10] = 16'h4F09; bprog[11] = 16'h800D;
    bprog[12] = 16'h4001; bprog[13] = 16'hE000;
  end

  // behavioural reference: mode 0 = executing, 1 = reading text, 2 = in a cell
  int m_pc = 0, m_mode = 0, m_cnt = 0, m_py = 0;
  bit m_kind = 0;
  logic [15:0] m_data = 0;

  always @(posedge clk) begin
    logic [15:0] w;
    int op, s;
    bit ok;
    w = bprog[m_pc];
    op = int'(w[15:13]);
    if (!rst_n) begin
      m_pc = 0; m_mode = 0; m_cnt = 0; m_py = 0; m_kind = 0; m_data = 0;
    end else begin
      if (beam_y == 0 && m_py != 0) begin
        m_pc = 0; m_mode = 0; m_cnt = 0;
      end else if (m_mode == 0) begin
        if (op == 0) begin if (int'(beam_y) == int'(w[12:0])) m_pc = (m_pc + 1) % 32; end
        else if (op == 1) begin if (int'(beam_x) == int'(w[12:0])) m_pc = (m_pc + 1) % 32; end
        else if (op == 2) begin
          s = int'(w[11:8]);
          ok = (s == 0) ? 1'b1 : (s == 1) ? 1'b0 : cond_flags[s-2];
          m_pc = (m_pc + 1) % 32;
          if (ok) begin m_data = {w[7:0], w[7:0] ^ salt}; m_kind = 0; m_mode = 2; m_cnt = 0; end
        end
        else if (op == 3) begin m_pc = (m_pc + 1) % 32; m_mode = 1; end
        else if (op == 4) m_pc = int'(w[4:0]);
      end else if (m_mode == 1) begin
        m_pc = (m_pc + 1) % 32;
        if (w == 0) m_mode = 0;
        else begin m_data = w; m_kind = 1; m_mode = 2; m_cnt = 0; end
      end else if (disp_en) begin
        m_cnt++;
        if (m_cnt == 8) m_mode = m_kind ? 1 : 0;
      end
      m_py = int'(beam_y);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit mv;
    mv = (m_mode == 2);
    check(dbg_idx == bprog[m_pc][7:0], "R4", "dbg_idx", 16'(dbg_idx), 16'(bprog[m_pc][7:0]));
    check(draw_valid == mv, "R5", "draw_valid", 16'(draw_valid), 16'(mv));
    check(draw_kind == m_kind, "R6", "draw_kind", 16'(draw_kind), 16'(m_kind));
    check(draw_data == m_data, m_kind ? "R6" : "R4", "draw_data", draw_data, m_data);
    check(pix_active == (mv && disp_en), "R10", "pix_active", 16'(pix_active), 16'(mv && disp_en));
  endtask

  initial begin
    int nval, ntxt, exp_val;
    bit last_dv, first_seen;
    repeat (3) @(negedge clk);
    check(!draw_valid && !pix_active && dbg_idx == 8'h02, "R1", "reset state",
          {dbg_idx, 6'b0, draw_valid, pix_active}, 16'h0200);
    rst_n = 1;
    for (int f = 0; f < FRAMES; f++) begin
      case (f % 4)
        0: cond_flags = 14'h3FFF;
        1: cond_flags = 14'h0000;
        2: cond_flags = 14'h0001;
        default: cond_flags = 14'h2000;
      endcase
      exp_val = 1 + int'(cond_flags[0]) + int'(cond_flags[13]);
      salt = 8'(f * 37 + 5);
      nval = 0; ntxt = 0; last_dv = 0; first_seen = 0;
      for (int y = 0; y < H; y++) begin
        for (int x = 0; x < W; x++) begin
          beam_x = 10'(x); beam_y = 10'(y); disp_en = (x < ACT);
          @(negedge clk);
          compare_all();
          if (draw_valid && !last_dv) begin
            if (draw_kind) ntxt++; else nval++;
            if (!first_seen) begin
              first_seen = 1;
              check(y == 2 && x == 4, "R2", "first cell position (R3 column wait)",
                    16'(y * 256 + x), 16'h0204);
            end
          end
          last_dv = draw_valid;
          if (f > 0 && y == 0 && x == 0)
            check(dbg_idx == 8'h02 && !draw_valid, "R9", "restart to word 0",
                  {dbg_idx, 7'b0, draw_valid}, 16'h0200);
          if (y == H - 1 && x == 20)
            check(dbg_idx == 8'h00 && !draw_valid, "R8", "halted at end of program",
                  {dbg_idx, 7'b0, draw_valid}, 16'h0000);
        end
      end
      check(nval == exp_val, "R7", "value cells per frame (R5 selects)", 16'(nval), 16'(exp_val));
      check(ntxt == 2, "R6", "text cells per frame", 16'(ntxt), 16'd2);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule